// File: doc/BRIEF.md
# Performance-Monitor Register Access Trap Resolver

This block decides whether a software read or write of a performance-monitor overflow status register completes, or traps to a higher privilege level. Each request carries the current privilege level (0 to 3), the access direction, and a snapshot of the controls that govern the decision. Those controls are: whether level 3 is present, which of levels 1 to 3 run in the 32-bit execution state, the hypervisor-enabled flag, the user-access enable, the hypervisor host and routing bits, the separate fine-grained read and write trap bits, the fine-grained enable from level 3, and the trap-monitor bits at levels 2 and 3.

The checks form an ordered chain, and which checks take part depends on the privilege level. The first check that matches decides the trap and its target level. When no check matches, the access is allowed. Every trap reports syndrome class 0x18. Requests enter through a valid/ready handshake, and the verdict leaves through a second valid/ready handshake. The verdict is registered, so it appears one cycle after acceptance. A request is accepted whenever the output slot is empty or is being drained in the same cycle. While a verdict waits for `rsp_ready`, the next request is held off. All control inputs must be stable in the cycle a request is accepted.

Top module: `pmu_access_gate`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request produces `rsp_valid` on the following cycle. While `rsp_valid` is high and `rsp_ready` is low, the verdict stays valid and unchanged. A new request may be accepted in the same cycle the previous verdict is taken.
- R2: While `rsp_valid` is high, exactly one of `rsp_allow` and `rsp_trap` is 1. An allowed access reports target 0 and class 0. A trap reports class 0x18.
- R3: At level 0, if `l1_narrow` is 0 and `user_en` is 0, the access traps. The target is 2 when `hyp_en`=1, `l2_narrow`=0 and `route_bit`=1. Otherwise the target is 1.
- R4: At level 0, a fine-grained trap to level 2 is taken when all of the following hold: `hyp_en`=1, `l1_narrow`=0, `host_bit` and `route_bit` are not both 1, fine-grained traps are active, and the fine-grained bit for the access direction is 1. Fine-grained traps are active when `l3_present`=0 or `fg_enable`=1.
- R5: At level 1, a fine-grained trap to level 2 is taken when `hyp_en`=1, `l2_narrow`=0, fine-grained traps are active, and the direction bit is 1. `host_bit` and `route_bit` play no part here.
- R6: At levels 0 and 1, the access traps to level 2 when `hyp_en`=1, `l2_narrow`=0 and `mon2_trap`=1.
- R7: At levels 0, 1 and 2, the access traps to level 3 when `l3_present`=1, `l3_narrow`=0 and `mon3_trap`=1.
- R8: At level 2, only the R7 check applies. At level 3, every access is allowed.
- R9: A read (`req_write`=0) consults only `fg_rd_trap`. A write (`req_write`=1) consults only `fg_wr_trap`.
- R10: A trap always targets a level above the requesting level.
- R11: The checks are evaluated in priority order, and the first match decides. At level 0 the order is R3, R4, R6, R7. At level 1 the order is R5, R6, R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cur_lvl | input | 2 | Privilege level of the access |
| l3_present | input | 1 | Level 3 is implemented |
| l1_narrow | input | 1 | Level 1 runs in 32-bit state |
| l2_narrow | input | 1 | Level 2 runs in 32-bit state |
| l3_narrow | input | 1 | Level 3 runs in 32-bit state |
| hyp_en | input | 1 | Hypervisor enabled in the current security state |
| user_en | input | 1 | User-level access enable |
| host_bit | input | 1 | Hypervisor host-mode bit |
| route_bit | input | 1 | Hypervisor general-trap routing bit |
| fg_rd_trap | input | 1 | Fine-grained trap for reads |
| fg_wr_trap | input | 1 | Fine-grained trap for writes |
| fg_enable | input | 1 | Fine-grained traps enabled by level 3 |
| mon2_trap | input | 1 | Level-2 trap-monitor bit |
| mon3_trap | input | 1 | Level-3 trap-monitor bit |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict consumed when high with `rsp_valid` |
| rsp_allow | output | 1 | Access completes |
| rsp_trap | output | 1 | Access traps |
| rsp_target | output | 2 | Level the trap goes to |
| rsp_class | output | 6 | Syndrome class of the trap |

## Verification
Two things can fall in the same cycle: the draining of a finished verdict and the acceptance of the next request. The bench provokes this by holding `rsp_ready` high while a second request, with a different expected outcome, waits on the input. It then checks that each verdict belongs to its own request. The bench also holds `rsp_ready` low with a request pending. It checks that `req_ready` drops and that the old verdict stays unchanged. It then checks that the pending request is taken in the cycle the stall lifts.

// File: rtl/pag_pkg.sv
package pag_pkg;
  localparam int LVL_W = 2;

  typedef struct packed {
    logic             trap;
    logic [LVL_W-1:0] target;
  } pag_verdict_t;
endpackage

// File: rtl/pag_fg_select.sv
module pag_fg_select (
  input  logic is_write,
  input  logic rd_bit,
  input  logic wr_bit,
  input  logic l3_present,
  input  logic l3_fg_enable,
  output logic fg_hit
);
  logic dir_bit;
  logic fg_active;

  // direction picks exactly one of the two trap bits
  assign dir_bit   = is_write ? wr_bit : rd_bit;
  // without level 3 the fine-grained controls are always live
  assign fg_active = !l3_present || l3_fg_enable;
  assign fg_hit    = dir_bit && fg_active;
endmodule

// File: rtl/pag_rule_chain.sv
module pag_rule_chain
  import pag_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             fg_hit,
  input  logic             l3_present,
  input  logic             l1_narrow,
  input  logic             l2_narrow,
  input  logic             l3_narrow,
  input  logic             hyp_en,
  input  logic             user_en,
  input  logic             host_bit,
  input  logic             route_bit,
  input  logic             mon2_trap,
  input  logic             mon3_trap,
  output pag_verdict_t     verdict
);
  localparam int NUM_RULES = 5;
  localparam int NUM_LVL   = 1 << LVL_W;
  // Per rule, one bit per level where that rule takes part. Rule index is priority.
  localparam logic [NUM_RULES*NUM_LVL-1:0] RULE_LVLS = {
    4'b0111,   // rule 4: level-3 monitor, levels 0..2
    4'b0011,   // rule 3: level-2 monitor, levels 0..1
    4'b0010,   // rule 2: fine-grained, level-1 form
    4'b0001,   // rule 1: fine-grained, level-0 form
    4'b0001    // rule 0: user enable
  };

  logic             hyp64, kern64, mon64;
  logic [NUM_RULES-1:0] hit;
  logic [NUM_RULES-1:0] live;
  logic [LVL_W-1:0]     tgt [NUM_RULES];

  assign hyp64  = hyp_en && !l2_narrow;
  assign kern64 = !l1_narrow;
  assign mon64  = l3_present && !l3_narrow;

  assign hit[0] = kern64 && !user_en;
  assign tgt[0] = (hyp64 && route_bit) ? LVL_W'(2) : LVL_W'(1);
  assign hit[1] = hyp_en && kern64 && !(host_bit && route_bit) && fg_hit;
  assign tgt[1] = LVL_W'(2);
  assign hit[2] = hyp64 && fg_hit;
  assign tgt[2] = LVL_W'(2);
  assign hit[3] = hyp64 && mon2_trap;
  assign tgt[3] = LVL_W'(2);
  assign hit[4] = mon64 && mon3_trap;
  assign tgt[4] = LVL_W'(3);

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_gate
    assign live[r] = hit[r] && RULE_LVLS[r*NUM_LVL + int'(cur_lvl)];
  end

  always_comb begin
    verdict = '0;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (live[r]) begin
        verdict.trap   = 1'b1;
        verdict.target = tgt[r];
      end
    end
  end
endmodule

// File: rtl/pag_rsp_reg.sv
module pag_rsp_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R1: a stalled verdict is kept intact
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R1: acceptance gives a verdict on the next cycle
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pag_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = CLASS_W'(6'h18)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic               l3_present,
  input  logic               l1_narrow,
  input  logic               l2_narrow,
  input  logic               l3_narrow,
  input  logic               hyp_en,
  input  logic               user_en,
  input  logic               host_bit,
  input  logic               route_bit,
  input  logic               fg_rd_trap,
  input  logic               fg_wr_trap,
  input  logic               fg_enable,
  input  logic               mon2_trap,
  input  logic               mon3_trap,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_allow,
  output logic               rsp_trap,
  output logic [LVL_W-1:0]   rsp_target,
  output logic [CLASS_W-1:0] rsp_class
);
  localparam int VW = $bits(pag_verdict_t);

  logic         fg_hit;
  pag_verdict_t verdict_d;
  pag_verdict_t verdict_q;

  pag_fg_select u_fg (
    .is_write     (req_write),
    .rd_bit       (fg_rd_trap),
    .wr_bit       (fg_wr_trap),
    .l3_present   (l3_present),
    .l3_fg_enable (fg_enable),
    .fg_hit       (fg_hit)
  );

  pag_rule_chain u_chain (
    .cur_lvl    (cur_lvl),
    .fg_hit     (fg_hit),
    .l3_present (l3_present),
    .l1_narrow  (l1_narrow),
    .l2_narrow  (l2_narrow),
    .l3_narrow  (l3_narrow),
    .hyp_en     (hyp_en),
    .user_en    (user_en),
    .host_bit   (host_bit),
    .route_bit  (route_bit),
    .mon2_trap  (mon2_trap),
    .mon3_trap  (mon3_trap),
    .verdict    (verdict_d)
  );

  pag_rsp_reg #(.W(VW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (verdict_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (verdict_q)
  );

  assign rsp_trap   = rsp_valid && verdict_q.trap;
  assign rsp_allow  = rsp_valid && !verdict_q.trap;
  assign rsp_target = rsp_trap ? verdict_q.target : '0;
  assign rsp_class  = rsp_trap ? TRAP_CLASS : '0;

  // R2: a valid verdict is either allow or trap
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_allow != rsp_trap));
  // R2: trap carries the fixed class
  a_r2_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_class == TRAP_CLASS);
  // R10: the chain never routes a trap to the same or a lower level
  a_r10_target_above: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_d.trap |-> verdict_d.target > cur_lvl);
  // R8: top level always completes
  a_r8_top_allows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cur_lvl == LVL_W'(3) |=> rsp_allow);
endmodule

// File: tb/pmu_access_gate_test.sv
module pmu_access_gate_test;
  localparam int P3 = 1 << 0, N1 = 1 << 1, N2 = 1 << 2, N3 = 1 << 3, HYP = 1 << 4,
                 UE = 1 << 5, HOST = 1 << 6, ROUTE = 1 << 7, FGR = 1 << 8, FGW = 1 << 9,
                 FGE = 1 << 10, TPM2 = 1 << 11, TPM3 = 1 << 12;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0] cur_lvl = 0;
  logic [12:0] s = 0;
  logic req_ready, rsp_valid, rsp_allow, rsp_trap;
  logic [1:0] rsp_target;
  logic [5:0] rsp_class;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmu_access_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .cur_lvl(cur_lvl), .l3_present(s[0]), .l1_narrow(s[1]),
    .l2_narrow(s[2]), .l3_narrow(s[3]), .hyp_en(s[4]), .user_en(s[5]), .host_bit(s[6]),
    .route_bit(s[7]), .fg_rd_trap(s[8]), .fg_wr_trap(s[9]), .fg_enable(s[10]),
    .mon2_trap(s[11]), .mon3_trap(s[12]), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_allow(rsp_allow), .rsp_trap(rsp_trap), .rsp_target(rsp_target), .rsp_class(rsp_class)
  );

  // independent model written from the requirements; returns {trap, target}
  function automatic logic [2:0] model(input logic [1:0] el, input logic wr, input logic [12:0] v);
    logic fg;
    fg = (wr ? v[9] : v[8]) && (!v[0] || v[10]);
    if (el == 0) begin
      if (!v[1] && !v[5]) return {1'b1, (v[4] && !v[2] && v[7]) ? 2'd2 : 2'd1};
      if (v[4] && !v[1] && !(v[6] && v[7]) && fg) return 3'b110;
      if (v[4] && !v[2] && v[11]) return 3'b110;
      if (v[0] && !v[3] && v[12]) return 3'b111;
    end else if (el == 1) begin
      if (v[4] && !v[2] && fg) return 3'b110;
      if (v[4] && !v[2] && v[11]) return 3'b110;
      if (v[0] && !v[3] && v[12]) return 3'b111;
    end else if (el == 2) begin
      if (v[0] && !v[3] && v[12]) return 3'b111;
    end
    return 3'b000;
  endfunction

  task automatic check_out(input string req, input logic etrap, input logic [1:0] etgt);
    logic [10:0] act, exp;
    act = {rsp_valid, rsp_allow, rsp_trap, rsp_target, rsp_class};
    exp = {1'b1, !etrap, etrap, etrap ? etgt : 2'd0, etrap ? 6'h18 : 6'h00};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v/al/tr/tg/cl=%b expected %b (lvl %0d wr %0b ctl %h)",
               req, act, exp, cur_lvl, req_write, s);
    end
  endtask

  task automatic issue(input logic [1:0] el, input logic wr, input int v,
                       input logic etrap, input logic [1:0] etgt, input string req);
    cur_lvl = el; req_write = wr; s = v[12:0]; req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check_out(req, etrap, etgt);
  endtask

  task automatic t_reset;
    tests++;
    if (rsp_valid !== 0 || rsp_trap !== 0 || rsp_allow !== 0 || req_ready !== 1) begin
      fails++;
      $display("FAIL R1 reset: v=%b tr=%b al=%b rdy=%b expected 0 0 0 1",
               rsp_valid, rsp_trap, rsp_allow, req_ready);
    end
  endtask

  task automatic t_user_gate;
    issue(0, 0, 0, 1, 1, "R3 user disabled -> 1");
    issue(0, 0, HYP | ROUTE, 1, 2, "R3 routed -> 2");
    issue(0, 0, HYP | ROUTE | N2, 1, 1, "R3 narrow hyp -> 1");
    issue(0, 0, N1, 0, 0, "R3 narrow level1 skips");
    issue(0, 1, UE, 0, 0, "R3 enabled allows");
  endtask

  task automatic t_fine_l0;
    issue(0, 0, UE | HYP | FGR, 1, 2, "R4 read fg");
    issue(0, 0, UE | HYP | FGR | P3, 0, 0, "R4 fg disabled by level3");
    issue(0, 0, UE | HYP | FGR | P3 | FGE, 1, 2, "R4 fg enabled by level3");
    issue(0, 0, UE | HYP | FGR | HOST | ROUTE, 0, 0, "R4 host+route bypass");
    issue(0, 0, UE | HYP | FGR | HOST, 1, 2, "R4 host only");
    issue(0, 0, UE | HYP | FGR | N2, 1, 2, "R4 ignores level2 width");
  endtask

  task automatic t_direction;
    issue(0, 1, UE | HYP | FGR, 0, 0, "R9 write ignores read bit");
    issue(0, 1, UE | HYP | FGW, 1, 2, "R9 write bit");
    issue(0, 0, UE | HYP | FGW, 0, 0, "R9 read ignores write bit");
    issue(1, 1, HYP | FGW, 1, 2, "R9 level1 write bit");
  endtask

  task automatic t_fine_l1;
    issue(1, 0, HYP | FGR | HOST | ROUTE, 1, 2, "R5 host+route no effect");
    issue(1, 0, HYP | FGR | N2, 0, 0, "R5 narrow level2");
    issue(1, 0, HYP | FGR | P3, 0, 0, "R5 fg off");
  endtask

  task automatic t_monitors;
    issue(1, 0, HYP | TPM2, 1, 2, "R6 level1");
    issue(0, 0, UE | HYP | TPM2, 1, 2, "R6 level0");
    issue(1, 0, HYP | N2 | TPM2, 0, 0, "R6 narrow level2");
    issue(1, 0, P3 | TPM3, 1, 3, "R7 level1");
    issue(1, 0, P3 | N3 | TPM3, 0, 0, "R7 narrow level3");
    issue(1, 0, TPM3, 0, 0, "R7 level3 absent");
    issue(2, 0, P3 | TPM3, 1, 3, "R7 level2");
  endtask

  task automatic t_upper;
    issue(2, 0, HYP | TPM2 | FGR, 0, 0, "R8 level2 skips lower checks");
    issue(3, 1, P3 | TPM3 | HYP | TPM2 | FGW, 0, 0, "R8 level3 allows");
    issue(2, 1, 0, 0, 0, "R8 level2 default allow");
  endtask

  task automatic t_priority;
    issue(0, 0, HYP | ROUTE | TPM2 | P3 | TPM3, 1, 2, "R11 user gate first");
    issue(0, 0, HYP | TPM2 | P3 | TPM3, 1, 1, "R11 user gate unrouted");
    issue(1, 0, HYP | TPM2 | P3 | TPM3, 1, 2, "R11 level2 monitor before level3");
    issue(0, 0, UE | P3 | TPM3 | HYP | FGR | FGE, 1, 2, "R11 fg before level3");
  endtask

  task automatic t_back_to_back;
    cur_lvl = 1; req_write = 0; s = P3 | TPM3; req_valid = 1;
    @(posedge clk); @(negedge clk);
    check_out("R1 first of pair", 1, 3);
    cur_lvl = 3; s = P3 | TPM3;
    tests++;
    if (req_ready !== 1) begin fails++; $display("FAIL R1 ready while draining: got %b expected 1", req_ready); end
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check_out("R1 second of pair", 0, 0);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_backpressure;
    rsp_ready = 0;
    issue(0, 0, 0, 1, 1, "R1 stalled verdict");
    cur_lvl = 3; s = 0; req_valid = 1;
    tests++;
    if (req_ready !== 0) begin fails++; $display("FAIL R1 ready under stall: got %b expected 0", req_ready); end
    @(posedge clk); @(negedge clk);
    check_out("R1 verdict held", 1, 1);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check_out("R1 pending taken after stall", 0, 0);
    @(posedge clk); @(negedge clk);
    tests++;
    if (rsp_valid !== 0) begin fails++; $display("FAIL R1 drained: got %b expected 0", rsp_valid); end
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 2048; i++) begin
      for (int el = 0; el < 4; el++) begin
        for (int wr = 0; wr < 2; wr++) begin
          logic [12:0] v;
          logic [2:0] e;
          v = 13'((i * 613) ^ (i >> 2));
          e = model(2'(el), wr[0], v);
          issue(2'(el), wr[0], int'(v), e[2], e[1:0], "R2/R10 sweep");
          if (e[2] && e[1:0] <= 2'(el)) begin
            fails++; $display("FAIL R10 model target %0d expected above %0d", e[1:0], el);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_user_gate;
    t_fine_l0;
    t_direction;
    t_fine_l1;
    t_monitors;
    t_upper;
    t_priority;
    t_back_to_back;
    t_backpressure;
    t_sweep;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule